// File: doc/BRIEF.md
# Serial EEPROM Image Loader

After reset this block copies the whole contents of a three-wire serial EEPROM (chip select, serial clock, data in, data out) into an internal array of 16-bit words and checks that the image is valid. The EEPROM may be shared with another agent. Before it drives a single pin, the block raises an access request and waits until it sees the grant. Grant is checked at fixed poll intervals, and the wait is given up after a set number of polls.

Each word is fetched with its own read frame: a three-bit read opcode, then the word address, then sixteen data bits clocked back from the device. An input flag selects whether the address is six bits wide (a 64-word part) or eight bits wide (a 256-word part). Only the first 64 words are loaded in either case. While the words arrive, the block keeps a 16-bit wrapping sum of them. The image is declared good when that sum equals a fixed signature.

After loading ends, whether it passed or failed, the request is dropped. Host logic may then take over the EEPROM pins directly through a bypass path. The loaded words can be read at any time through a combinational read port.

Top module: `eeprom_loader`

## Requirements
- R1: After reset, with `present_i`=1 and `spi_part_i`=0, `arb_req_o` rises. `ee_cs_o` and `ee_sk_o` stay low until `arb_gnt_i` has been seen high at a poll.
- R2: If no poll sees the grant within `GNT_POLLS` polls spaced `POLL_GAP` cycles apart, the load ends. At that point `timeout_o`=1, `done_o`=1, `checksum_ok_o`=0 and `arb_req_o`=0.
- R3: When `spi_part_i`=1 or `present_i`=0, the load ends at once with `checksum_ok_o`=0, and `arb_req_o` is never raised.
- R4: Each word is fetched in one frame, with chip select held high. The block sends the read opcode 1,1,0, then the address MSB first. The address is 6 bits when `size_wide_i`=0 and 8 bits when `size_wide_i`=1. The block then takes in 16 data bits MSB first. Data in changes while the serial clock is low, and data out is sampled at the end of the serial clock high phase.
- R5: Between two frames, chip select stays low for at least 2*`SK_HALF` cycles.
- R6: Words 0 to 63 are stored in address order. `rd_data_o` shows the word at `rd_addr_i` with no cycle of delay.
- R7: `checksum_ok_o` is 1 exactly when the sum of the 64 words, taken modulo 2^16, equals `SIGNATURE` (0xBABA by default).
- R8: `arb_req_o` is low once `done_o` is high, whether the load passed or failed.
- R9: When `done_o`=1 and `host_en_i`=1, the EEPROM outputs follow `host_sk_i`, `host_cs_i` and `host_di_i`. Before `done_o` rises, the host inputs have no effect on the pins.
- R10: `done_o` and `checksum_ok_o` keep their values until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| present_i | input | 1 | An EEPROM is fitted |
| spi_part_i | input | 1 | The fitted part is SPI, which this block does not handle |
| size_wide_i | input | 1 | 1: 8-bit addressing, 0: 6-bit addressing |
| arb_req_o | output | 1 | Access request to the arbiter |
| arb_gnt_i | input | 1 | Access grant from the arbiter |
| ee_sk_o | output | 1 | Serial clock to the EEPROM |
| ee_cs_o | output | 1 | Chip select to the EEPROM |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| ee_do_i | input | 1 | Serial data from the EEPROM |
| host_en_i | input | 1 | Hand the pins to the host after loading |
| host_sk_i | input | 1 | Host serial clock |
| host_cs_i | input | 1 | Host chip select |
| host_di_i | input | 1 | Host serial data |
| rd_addr_i | input | 6 | Word array read address |
| rd_data_o | output | 16 | Word array read data |
| done_o | output | 1 | Loading has ended |
| checksum_ok_o | output | 1 | The image sum matched the signature |
| timeout_o | output | 1 | Loading ended because the grant never arrived |

## Verification
The bench builds the loader with `SK_HALF`=2, `POLL_GAP`=3 and `GNT_POLLS`=6. The default values take about a million cycles to reach a grant timeout. With these values a timeout comes within a few dozen cycles, and each 64-word load, in either address width, finishes in under eight thousand cycles. That leaves time in one run to cover a valid image, a corrupted image, a mismatch between the address width and the part, a delayed grant and a timeout.

// File: rtl/eeld_pkg.sv
package eeld_pkg;
  localparam int unsigned ADDR_MAX_W = 8;
  localparam int unsigned CMD_W      = 3 + ADDR_MAX_W;
  localparam logic [2:0]  OPC_READ   = 3'b110;

  typedef enum logic [2:0] {
    L_CHECK, L_ARB, L_START, L_WAIT, L_FINISH, L_DONE
  } ld_state_e;

  typedef enum logic [1:0] {
    SH_IDLE, SH_GAP, SH_LOW, SH_HIGH
  } sh_state_e;
endpackage

// File: rtl/eeld_arb.sv
module eeld_arb #(
  parameter int unsigned GNT_POLLS = 1000,
  parameter int unsigned POLL_GAP  = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic release_i,
  input  logic gnt_i,
  output logic req_o,
  output logic granted_o,
  output logic timeout_o
);
  localparam int unsigned GW = $clog2(POLL_GAP + 1);
  localparam int unsigned PW = $clog2(GNT_POLLS + 1);

  logic          active_q;
  logic [GW-1:0] gap_q;
  logic [PW-1:0] poll_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o     <= 1'b0;
      active_q  <= 1'b0;
      gap_q     <= '0;
      poll_q    <= '0;
      granted_o <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      granted_o <= 1'b0;
      timeout_o <= 1'b0;
      if (release_i) req_o <= 1'b0;
      if (start_i) begin
        req_o    <= 1'b1;
        active_q <= 1'b1;
        gap_q    <= '0;
        poll_q   <= '0;
      end else if (active_q) begin
        if (gap_q == GW'(POLL_GAP - 1)) begin
          gap_q <= '0;
          if (gnt_i) begin
            granted_o <= 1'b1;
            active_q  <= 1'b0;
          end else if (poll_q == PW'(GNT_POLLS - 1)) begin
            timeout_o <= 1'b1;
            active_q  <= 1'b0;
            req_o     <= 1'b0;
          end else begin
            poll_q <= poll_q + 1'b1;
          end
        end else begin
          gap_q <= gap_q + 1'b1;
        end
      end
    end
  end

  p_grant_with_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    granted_o |-> req_o);
  p_timeout_drops_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !req_o && !granted_o);
endmodule

// File: rtl/eeld_shift.sv
module eeld_shift
  import eeld_pkg::*;
#(
  parameter int unsigned DW      = 16,
  parameter int unsigned SK_HALF = 50
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  wide_i,
  input  logic [ADDR_MAX_W-1:0] addr_i,
  output logic                  done_o,
  output logic [DW-1:0]         data_o,
  output logic                  sk_o,
  output logic                  cs_o,
  output logic                  di_o,
  input  logic                  do_i
);
  localparam int unsigned CW = $clog2(2 * SK_HALF + 1);
  localparam int unsigned BW = $clog2(CMD_W + DW + 1);

  sh_state_e      st_q;
  logic [CW-1:0]  cnt_q;
  logic [BW-1:0]  bit_q, ncmd_q;
  logic [CMD_W-1:0] cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SH_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      ncmd_q <= '0;
      cmd_q  <= '0;
      data_o <= '0;
      done_o <= 1'b0;
      sk_o   <= 1'b0;
      cs_o   <= 1'b0;
      di_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        SH_IDLE: if (start_i) begin
          cmd_q  <= wide_i ? {OPC_READ, addr_i} : {OPC_READ, addr_i[5:0], 2'b00};
          ncmd_q <= wide_i ? BW'(CMD_W) : BW'(CMD_W - 2);
          cnt_q  <= '0;
          st_q   <= SH_GAP;
        end
        SH_GAP: begin
          if (cnt_q == CW'(2 * SK_HALF - 1)) begin
            cnt_q <= '0;
            bit_q <= '0;
            cs_o  <= 1'b1;
            di_o  <= cmd_q[CMD_W-1];
            st_q  <= SH_LOW;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SH_LOW: begin
          if (cnt_q == CW'(SK_HALF - 1)) begin
            cnt_q <= '0;
            sk_o  <= 1'b1;
            st_q  <= SH_HIGH;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SH_HIGH: begin
          if (cnt_q == CW'(SK_HALF - 1)) begin
            cnt_q <= '0;
            sk_o  <= 1'b0;
            if (bit_q >= ncmd_q) data_o <= {data_o[DW-2:0], do_i};
            if (bit_q == ncmd_q + BW'(DW - 1)) begin
              cs_o   <= 1'b0;
              di_o   <= 1'b0;
              done_o <= 1'b1;
              st_q   <= SH_IDLE;
            end else begin
              bit_q <= bit_q + 1'b1;
              cmd_q <= cmd_q << 1;
              di_o  <= (bit_q + 1'b1 < ncmd_q) ? cmd_q[CMD_W-2] : 1'b0;
              st_q  <= SH_LOW;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end

  p_sk_in_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sk_o |-> cs_o);
  p_di_stable_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sk_o && $past(sk_o)) |-> $stable(di_o));
  p_cs_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |=> !cs_o);
endmodule

// File: rtl/eeld_store.sv
module eeld_store #(
  parameter int unsigned WORDS = 64,
  parameter int unsigned DW    = 16,
  localparam int unsigned IW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          wr_i,
  input  logic [IW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [IW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] sum_o
);
  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
      sum_o <= '0;
    end else if (clear_i) begin
      sum_o <= '0;
    end else if (wr_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
      sum_o            <= sum_o + wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/eeprom_loader.sv
module eeprom_loader
  import eeld_pkg::*;
#(
  parameter int unsigned WORDS     = 64,
  parameter int unsigned DW        = 16,
  parameter logic [15:0] SIGNATURE = 16'hBABA,
  parameter int unsigned GNT_POLLS = 1000,
  parameter int unsigned POLL_GAP  = 1000,
  parameter int unsigned SK_HALF   = 50,
  localparam int unsigned IW       = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          present_i,
  input  logic          spi_part_i,
  input  logic          size_wide_i,
  output logic          arb_req_o,
  input  logic          arb_gnt_i,
  output logic          ee_sk_o,
  output logic          ee_cs_o,
  output logic          ee_di_o,
  input  logic          ee_do_i,
  input  logic          host_en_i,
  input  logic          host_sk_i,
  input  logic          host_cs_i,
  input  logic          host_di_i,
  input  logic [IW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          done_o,
  output logic          checksum_ok_o,
  output logic          timeout_o
);
  ld_state_e     st_q;
  logic [IW-1:0] idx_q;
  logic          arb_start, arb_release, granted, arb_to;
  logic          sh_start, sh_done, sh_sk, sh_cs, sh_di;
  logic [DW-1:0] sh_data, sum;
  logic          host_mode;

  assign arb_start   = (st_q == L_CHECK) && present_i && !spi_part_i;
  assign arb_release = (st_q == L_FINISH);
  assign sh_start    = (st_q == L_START);

  eeld_arb #(.GNT_POLLS(GNT_POLLS), .POLL_GAP(POLL_GAP)) u_arb (
    .clk_i, .rst_ni,
    .start_i(arb_start), .release_i(arb_release), .gnt_i(arb_gnt_i),
    .req_o(arb_req_o), .granted_o(granted), .timeout_o(arb_to)
  );

  eeld_shift #(.DW(DW), .SK_HALF(SK_HALF)) u_shift (
    .clk_i, .rst_ni,
    .start_i(sh_start), .wide_i(size_wide_i),
    .addr_i({{(ADDR_MAX_W-IW){1'b0}}, idx_q}),
    .done_o(sh_done), .data_o(sh_data),
    .sk_o(sh_sk), .cs_o(sh_cs), .di_o(sh_di), .do_i(ee_do_i)
  );

  eeld_store #(.WORDS(WORDS), .DW(DW)) u_store (
    .clk_i, .rst_ni,
    .clear_i(arb_start), .wr_i(sh_done), .wr_addr_i(idx_q), .wr_data_i(sh_data),
    .rd_addr_i, .rd_data_o, .sum_o(sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= L_CHECK;
      idx_q         <= '0;
      checksum_ok_o <= 1'b0;
      timeout_o     <= 1'b0;
    end else begin
      unique case (st_q)
        L_CHECK: st_q <= (present_i && !spi_part_i) ? L_ARB : L_DONE;
        L_ARB: begin
          if (granted) begin
            idx_q <= '0;
            st_q  <= L_START;
          end else if (arb_to) begin
            timeout_o <= 1'b1;
            st_q      <= L_DONE;
          end
        end
        L_START: st_q <= L_WAIT;
        L_WAIT: if (sh_done) begin
          if (idx_q == IW'(WORDS - 1)) st_q <= L_FINISH;
          else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= L_START;
          end
        end
        L_FINISH: begin
          checksum_ok_o <= (sum == SIGNATURE[DW-1:0]);
          st_q          <= L_DONE;
        end
        default: st_q <= L_DONE;
      endcase
    end
  end

  assign done_o    = (st_q == L_DONE);
  assign host_mode = done_o && host_en_i;
  assign ee_sk_o   = host_mode ? host_sk_i : sh_sk;
  assign ee_cs_o   = host_mode ? host_cs_i : sh_cs;
  assign ee_di_o   = host_mode ? host_di_i : sh_di;

  p_cs_needs_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_cs || sh_sk) |-> arb_req_o);
  p_req_off_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !arb_req_o);
  p_done_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && $stable(checksum_ok_o) && $stable(timeout_o));
  p_ok_not_timeout_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !checksum_ok_o);
  p_no_req_bad_part_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == L_CHECK && (spi_part_i || !present_i)) |=> !arb_req_o);
endmodule

// File: tb/sim_eeprom_loader.sv
module sim_eeprom_loader;
  localparam int unsigned HALF  = 2;
  localparam int unsigned GAP   = 3;
  localparam int unsigned POLLS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic present = 1'b1, spi_part = 1'b0, size_wide = 1'b0;
  logic arb_req, arb_gnt = 1'b0, allow_gnt = 1'b1;
  logic ee_sk, ee_cs, ee_di, ee_do = 1'b0;
  logic host_en = 1'b0, host_sk = 1'b0, host_cs = 1'b0, host_di = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic done, ok, tout;

  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  eeprom_loader #(.GNT_POLLS(POLLS), .POLL_GAP(GAP), .SK_HALF(HALF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .present_i(present), .spi_part_i(spi_part),
    .size_wide_i(size_wide), .arb_req_o(arb_req), .arb_gnt_i(arb_gnt),
    .ee_sk_o(ee_sk), .ee_cs_o(ee_cs), .ee_di_o(ee_di), .ee_do_i(ee_do),
    .host_en_i(host_en), .host_sk_i(host_sk), .host_cs_i(host_cs), .host_di_i(host_di),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .done_o(done),
    .checksum_ok_o(ok), .timeout_o(tout)
  );

  always @(posedge clk) arb_gnt <= arb_req && allow_gnt;

  // EEPROM model
  logic [15:0] img [64];
  logic        model_wide = 1'b0;
  int          mcnt = 0, bad_op = 0;
  logic [10:0] cmd_in = '0;
  logic [7:0]  maddr = '0;

  always @(posedge ee_sk or negedge ee_cs) begin
    if (!ee_cs) mcnt = 0;
    else if (!u0.host_mode) begin
      if (mcnt < (model_wide ? 11 : 9)) begin
        cmd_in = {cmd_in[9:0], ee_di};
        if (mcnt == (model_wide ? 10 : 8)) begin
          if ((model_wide ? cmd_in[10:8] : cmd_in[8:6]) != 3'b110) bad_op++;
          maddr = model_wide ? cmd_in[7:0] : {2'b00, cmd_in[5:0]};
        end
      end
      mcnt++;
    end
  end

  always @(negedge ee_sk) begin
    int n;
    n = model_wide ? 11 : 9;
    if (ee_cs && mcnt >= n && mcnt < n + 16)
      ee_do = img[maddr[5:0]][15-(mcnt-n)];
  end

  // monitors
  int cs_low_run = 1000, gap_viol = 0, early_act = 0, req_seen = 0;
  always @(posedge clk) begin
    if (!ee_cs) cs_low_run <= cs_low_run + 1;
    else begin
      if (cs_low_run > 0 && cs_low_run < 2 * HALF && !u0.host_mode) gap_viol <= gap_viol + 1;
      cs_low_run <= 0;
    end
    if (!allow_gnt && !done && (ee_cs || ee_sk)) early_act <= early_act + 1;
    if (arb_req) req_seen <= req_seen + 1;
  end

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] img_sum();
    logic [15:0] s = '0;
    for (int i = 0; i < 64; i++) s = s + img[i];
    return s;
  endfunction

  task automatic make_good();
    logic [15:0] s = '0;
    for (int i = 0; i < 63; i++) begin
      img[i] = 16'(i * 16'h1357) ^ 16'h00A5;
      s = s + img[i];
    end
    img[63] = 16'hBABA - s;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    host_en = 1'b0;
    repeat (3) @(negedge clk);
    gap_viol = 0; early_act = 0; req_seen = 0; bad_op = 0;
    rst_n = 1'b1;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!done && !ok && !tout, "R10 reset outputs", {done, ok, tout}, 0);
    check(!ee_cs && !ee_sk && !arb_req, "R1 reset pins", {ee_cs, ee_sk, arb_req}, 0);
  endtask

  task automatic t_good(input bit wide);
    int cyc;
    make_good();
    size_wide = wide; model_wide = wide; allow_gnt = 1'b1;
    do_reset();
    wait_done(cyc);
    check(done && ok, wide ? "R7 wide image ok" : "R7 narrow image ok", {done, ok}, 3);
    check(!tout, "R2 no timeout", tout, 0);
    check(bad_op == 0, "R4 read opcode", bad_op, 0);
    check(gap_viol == 0, "R5 cs gap", gap_viol, 0);
    check(!arb_req, "R8 request released", arb_req, 0);
    foreach (img[i]) if (i == 0 || i == 17 || i == 40 || i == 63) begin
      rd_addr = 6'(i);
      #1;
      check(rd_data == img[i], "R6 stored word", rd_data, img[i]);
    end
  endtask

  task automatic t_bad_sum();
    int cyc;
    make_good();
    img[5] = img[5] ^ 16'h0001;
    size_wide = 1'b0; model_wide = 1'b0; allow_gnt = 1'b1;
    do_reset();
    wait_done(cyc);
    check(done && !ok, "R7 corrupt image rejected", {done, ok}, 2);
    rd_addr = 6'd5;
    #1;
    check(rd_data == img[5], "R6 corrupt word stored", rd_data, img[5]);
    check(img_sum() != 16'hBABA, "R7 bench image sum", img_sum(), 16'hBABA);
  endtask

  task automatic t_size_mismatch();
    int cyc;
    make_good();
    size_wide = 1'b0; model_wide = 1'b1; allow_gnt = 1'b1;
    do_reset();
    wait_done(cyc);
    check(done && !ok, "R4 width mismatch rejected", {done, ok}, 2);
    model_wide = 1'b0;
  endtask

  task automatic t_grant_delay();
    int cyc;
    make_good();
    size_wide = 1'b0; model_wide = 1'b0; allow_gnt = 1'b0;
    do_reset();
    repeat (10) @(negedge clk);
    check(arb_req, "R1 request raised", arb_req, 1);
    host_en = 1'b1; host_cs = 1'b1; host_sk = 1'b1;
    #1;
    check(!ee_cs && !ee_sk, "R9 host ignored before done", {ee_cs, ee_sk}, 0);
    host_en = 1'b0; host_cs = 1'b0; host_sk = 1'b0;
    repeat (POLLS * GAP - 14) @(negedge clk);
    check(early_act == 0, "R1 no pin activity before grant", early_act, 0);
    allow_gnt = 1'b1;
    wait_done(cyc);
    check(ok && !tout, "R1 load after late grant", {ok, tout}, 2);
  endtask

  task automatic t_timeout();
    int cyc;
    allow_gnt = 1'b0;
    do_reset();
    wait_done(cyc);
    check(done && tout && !ok, "R2 timeout result", {done, tout, ok}, 6);
    check(cyc >= POLLS * GAP && cyc <= POLLS * GAP + 6, "R2 timeout window", cyc, POLLS * GAP);
    check(!arb_req, "R8 request released after timeout", arb_req, 0);
    check(early_act == 0, "R1 pins idle without grant", early_act, 0);
    allow_gnt = 1'b1;
  endtask

  task automatic t_bad_part(input bit spi, input bit pres);
    int cyc;
    spi_part = spi; present = pres;
    do_reset();
    wait_done(cyc);
    repeat (5) @(negedge clk);
    check(done && !ok && cyc <= 3, "R3 unsupported part ends", cyc, 2);
    check(req_seen == 0, "R3 no request", req_seen, 0);
    spi_part = 1'b0; present = 1'b1;
  endtask

  task automatic t_host_bypass();
    int cyc;
    make_good();
    allow_gnt = 1'b1;
    do_reset();
    wait_done(cyc);
    host_en = 1'b1; host_cs = 1'b1; host_sk = 1'b0; host_di = 1'b1;
    #1;
    check(ee_cs && !ee_sk && ee_di, "R9 host drives pins", {ee_cs, ee_sk, ee_di}, 5);
    host_sk = 1'b1; host_di = 1'b0;
    #1;
    check(ee_sk && !ee_di, "R9 host pins follow", {ee_sk, ee_di}, 2);
    repeat (50) @(negedge clk);
    check(done && ok, "R10 result held", {done, ok}, 3);
    host_en = 1'b0; host_cs = 1'b0; host_sk = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_good(1'b0);
    t_good(1'b1);
    t_bad_sum();
    t_size_mismatch();
    t_grant_delay();
    t_timeout();
    t_bad_part(1'b1, 1'b1);
    t_bad_part(1'b0, 1'b0);
    t_host_bypass();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule